// File: doc/BRIEF.md
# Reconfiguration Stream Host Sequencer

This block is the host side of a reconfiguration data stream. When a request arrives while it is idle, it raises a start strobe for a fixed number of cycles. It then fetches words one at a time from a local word source through an index/data pair and offers them to a downstream sink with a valid/ready handshake. It respects backpressure and keeps each offered word steady until the sink takes it. It never offers the final word while start is still high.

After the final word has been accepted, the block can either go quiet or keep valid high with a constant filler word. It then waits for the sink to report the end of the operation. The sink can do this by dropping its freeze indication or by posting a new status code. If neither happens within a programmable number of cycles, a timeout ends the operation. The outcome is reported as a single-cycle done pulse, together with a pass flag or a fail flag.

Top module: `rcfg_stream_host`

## Requirements
- R1: While reset is held and in the first cycle after it is released, start_o, tx_valid_o, busy_o, done_o, pass_o and fail_o are all low.
- R2: A req_i sampled high while idle raises start_o and busy_o from the next cycle. start_o then stays high for exactly START_CYC consecutive cycles (default 2).
- R3: The words handed over are those at source indices 0 up to last_idx_i, in rising order. Each is handed over exactly once, and each carries the value src_data_i held when src_idx_o pointed at that index.
- R4: A cycle with tx_valid_o high and tx_ready_i low is followed by a cycle with tx_valid_o still high and tx_data_o unchanged, unless that cycle ends the operation.
- R5: The word at index last_idx_i is never offered while start_o is high.
- R6: With FILL_EN=1, after the final word is accepted tx_valid_o stays high with tx_data_o equal to FILL_VAL until done. With FILL_EN=0, tx_valid_o stays low after the final word.
- R7: While busy, a clock edge that samples freeze_i low after it was sampled high at the previous edge ends the operation. done_o is high in the following cycle.
- R8: While busy, a clock edge that samples status_i nonzero and different from its value at the previous edge ends the operation. done_o is high in the following cycle.
- R9: When done_o is high, exactly one of pass_o and fail_o is high. pass_o is set when status_i at the ending edge is 0 (nothing reported) or OK_CODE (default 1, success). Any other code sets fail_o. Both flags are low whenever done_o is low.
- R10: If no other ending occurs first, done_o rises with fail_o tmo_limit_i+1 edges after the edge that accepted the final word.
- R11: A req_i that arrives while busy is ignored. It does not produce a second start pulse and does not restart the word index.
- R12: done_o lasts exactly one cycle. tx_valid_o is low in that cycle, and the block is idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request to begin an operation (taken only while idle) |
| last_idx_i | input | IDX_W | Index of the final word, sampled with the request |
| tmo_limit_i | input | TMO_W | Timeout after the final word, sampled with the request |
| src_idx_o | output | IDX_W | Index presented to the word source |
| src_data_i | input | DATA_W | Word returned by the source for src_idx_o |
| start_o | output | 1 | Start strobe to the sink |
| tx_data_o | output | DATA_W | Word offered to the sink |
| tx_valid_o | output | 1 | tx_data_o is valid |
| tx_ready_i | input | 1 | Sink can take a word this cycle |
| freeze_i | input | 1 | Freeze indication from the sink |
| status_i | input | STAT_W | Status code from the sink |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation succeeded, valid with done_o |
| fail_o | output | 1 | Operation failed, valid with done_o |

## Verification
The bench sweeps every final index from 0 to 7 against four backpressure patterns. It targets the single-word stream, where a design that ignored the start interlock would offer that word while start was still high. It also checks that words held under backpressure stay frozen, since a feeder that advanced its index on every ready-low cycle would skip or repeat words. It measures the exact edge distance from freeze falling, from a status change, and from the final handshake to done; an off-by-one counter shows up as a shifted pulse. A request injected mid-stream must not produce a second start pulse or rewind the index.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
   typedef enum logic [1:0] {
      RS_IDLE  = 2'd0,
      RS_SEND  = 2'd1,
      RS_DRAIN = 2'd2
   } rcfg_phase_e;
endpackage

// File: rtl/rcfg_start_pulse.sv
module rcfg_start_pulse #(
   parameter int START_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic start_o
);
   localparam int CW = $clog2(START_CYC + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (fire_i)       cnt_q <= CW'(START_CYC);
      else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
   end

   assign start_o = (cnt_q != '0);

   AST_START_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> start_o);   // R2
endmodule

// File: rtl/rcfg_word_feeder.sv
module rcfg_word_feeder #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 8,
   parameter int FILL_EN = 1,
   parameter logic [DATA_W-1:0] FILL_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              begin_i,
   input  logic              abort_i,
   input  logic              run_i,
   input  logic              start_on_i,
   input  logic [IDX_W-1:0]  last_idx_i,
   output logic [IDX_W-1:0]  src_idx_o,
   input  logic [DATA_W-1:0] src_data_i,
   output logic [DATA_W-1:0] tx_data_o,
   output logic              tx_valid_o,
   input  logic              tx_ready_i,
   output logic              last_acc_o
);
   logic [IDX_W-1:0]  fetch_q, lim_q;
   logic [DATA_W-1:0] hold_q;
   logic              vld_q, more_q, last_q, post_q;
   logic              post_vld;
   logic [DATA_W-1:0] post_dat;
   logic              adv, last_hs, fetch_ok, at_last;

   generate
      if (FILL_EN != 0) begin : g_fill
         assign post_vld = 1'b1;
         assign post_dat = FILL_VAL;
      end else begin : g_nofill
         assign post_vld = 1'b0;
         assign post_dat = '0;
      end
   endgenerate

   assign at_last  = (fetch_q == lim_q);
   assign adv      = !vld_q || tx_ready_i;
   assign last_hs  = vld_q && tx_ready_i && last_q && !post_q;
   assign fetch_ok = run_i && !post_q && more_q && !(at_last && start_on_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fetch_q <= '0;
         lim_q   <= '0;
         hold_q  <= '0;
         vld_q   <= 1'b0;
         more_q  <= 1'b0;
         last_q  <= 1'b0;
         post_q  <= 1'b0;
      end else if (begin_i) begin
         fetch_q <= '0;
         lim_q   <= last_idx_i;
         vld_q   <= 1'b0;
         more_q  <= 1'b1;
         last_q  <= 1'b0;
         post_q  <= 1'b0;
      end else if (abort_i) begin
         vld_q   <= 1'b0;
         more_q  <= 1'b0;
         last_q  <= 1'b0;
         post_q  <= 1'b0;
      end else if (adv) begin
         if (last_hs) begin
            post_q <= 1'b1;
            last_q <= 1'b0;
            vld_q  <= post_vld;
            hold_q <= post_dat;
         end else if (!post_q) begin
            if (fetch_ok) begin
               hold_q  <= src_data_i;
               vld_q   <= 1'b1;
               last_q  <= at_last;
               more_q  <= !at_last;
               fetch_q <= fetch_q + IDX_W'(1);
            end else begin
               vld_q <= 1'b0;
            end
         end
      end
   end

   assign src_idx_o  = fetch_q;
   assign tx_data_o  = hold_q;
   assign tx_valid_o = vld_q;
   assign last_acc_o = last_hs && run_i;

   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !tx_ready_i && !abort_i && !begin_i) |=> (vld_q && $stable(hold_q)));   // R4
   AST_LAST_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && last_q && !post_q) |-> !start_on_i);   // R5
   AST_POST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      post_q |-> (vld_q == (FILL_EN != 0)));   // R6
endmodule

// File: rtl/rcfg_done_detect.sv
module rcfg_done_detect #(
   parameter int STAT_W  = 3,
   parameter int TMO_W   = 16,
   parameter int OK_CODE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              drain_i,
   input  logic [TMO_W-1:0]  tmo_limit_i,
   input  logic              freeze_i,
   input  logic [STAT_W-1:0] status_i,
   output logic              hit_o,
   output logic              ok_o
);
   localparam logic [STAT_W-1:0] OK_V = STAT_W'(OK_CODE);

   logic              freeze_q;
   logic [STAT_W-1:0] stat_q;
   logic [TMO_W-1:0]  tmo_q;
   logic              fz_fall, st_upd, st_good, tmo_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         freeze_q <= 1'b0;
         stat_q   <= '0;
         tmo_q    <= '0;
      end else begin
         freeze_q <= freeze_i;
         stat_q   <= status_i;
         if (!drain_i)                 tmo_q <= '0;
         else if (tmo_q != tmo_limit_i) tmo_q <= tmo_q + TMO_W'(1);
      end
   end

   assign fz_fall = freeze_q && !freeze_i;
   assign st_upd  = (status_i != stat_q) && (status_i != '0);
   assign st_good = (status_i == '0) || (status_i == OK_V);
   assign tmo_hit = drain_i && (tmo_q == tmo_limit_i);

   assign hit_o = active_i && (fz_fall || st_upd || tmo_hit);
   assign ok_o  = (fz_fall || st_upd) && st_good;

   AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      drain_i |-> (tmo_q <= tmo_limit_i));   // R10
endmodule

// File: rtl/rcfg_stream_host.sv
module rcfg_stream_host
   import rcfg_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int IDX_W     = 8,
   parameter int STAT_W    = 3,
   parameter int TMO_W     = 16,
   parameter int START_CYC = 2,
   parameter int FILL_EN   = 1,
   parameter logic [DATA_W-1:0] FILL_VAL = '0,
   parameter int OK_CODE   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [IDX_W-1:0]  last_idx_i,
   input  logic [TMO_W-1:0]  tmo_limit_i,
   output logic [IDX_W-1:0]  src_idx_o,
   input  logic [DATA_W-1:0] src_data_i,
   output logic              start_o,
   output logic [DATA_W-1:0] tx_data_o,
   output logic              tx_valid_o,
   input  logic              tx_ready_i,
   input  logic              freeze_i,
   input  logic [STAT_W-1:0] status_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              pass_o,
   output logic              fail_o
);
   generate
      if (START_CYC < 1) begin : g_bad_start
         $error("START_CYC must be at least 1");
      end
      if (FILL_EN != 0 && FILL_EN != 1) begin : g_bad_fill
         $error("FILL_EN must be 0 or 1");
      end
      if (STAT_W < 2 || OK_CODE < 1 || OK_CODE >= (1 << STAT_W)) begin : g_bad_ok
         $error("OK_CODE must be a nonzero code that fits in STAT_W");
      end
      if (IDX_W < 1 || TMO_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("widths must be positive");
      end
   endgenerate

   rcfg_phase_e      phase_q;
   logic [TMO_W-1:0] tmo_lim_q;
   logic             done_q, pass_q, fail_q;
   logic             req_go, hit, ok, last_acc;

   assign req_go = (phase_q == RS_IDLE) && req_i;

   rcfg_start_pulse #(.START_CYC(START_CYC)) u_start (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (req_go),
      .start_o (start_o)
   );

   rcfg_word_feeder #(
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .FILL_EN  (FILL_EN),
      .FILL_VAL (FILL_VAL)
   ) u_feed (
      .clk        (clk),
      .rst_n      (rst_n),
      .begin_i    (req_go),
      .abort_i    (hit),
      .run_i      (phase_q == RS_SEND),
      .start_on_i (start_o),
      .last_idx_i (last_idx_i),
      .src_idx_o  (src_idx_o),
      .src_data_i (src_data_i),
      .tx_data_o  (tx_data_o),
      .tx_valid_o (tx_valid_o),
      .tx_ready_i (tx_ready_i),
      .last_acc_o (last_acc)
   );

   rcfg_done_detect #(
      .STAT_W  (STAT_W),
      .TMO_W   (TMO_W),
      .OK_CODE (OK_CODE)
   ) u_done (
      .clk         (clk),
      .rst_n       (rst_n),
      .active_i    (phase_q != RS_IDLE),
      .drain_i     (phase_q == RS_DRAIN),
      .tmo_limit_i (tmo_lim_q),
      .freeze_i    (freeze_i),
      .status_i    (status_i),
      .hit_o       (hit),
      .ok_o        (ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= RS_IDLE;
         tmo_lim_q <= '0;
         done_q    <= 1'b0;
         pass_q    <= 1'b0;
         fail_q    <= 1'b0;
      end else begin
         done_q <= hit;
         pass_q <= hit && ok;
         fail_q <= hit && !ok;
         unique case (phase_q)
            RS_IDLE: if (req_i) begin
               phase_q   <= RS_SEND;
               tmo_lim_q <= tmo_limit_i;
            end
            RS_SEND: begin
               if (hit)           phase_q <= RS_IDLE;
               else if (last_acc) phase_q <= RS_DRAIN;
            end
            RS_DRAIN: if (hit) phase_q <= RS_IDLE;
            default: phase_q <= RS_IDLE;
         endcase
      end
   end

   assign busy_o = (phase_q != RS_IDLE);
   assign done_o = done_q;
   assign pass_o = pass_q;
   assign fail_o = fail_q;

   AST_FREEZE_END: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $fell(freeze_i)) |=> done_o);   // R7
   AST_STATUS_END: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && status_i != '0 && status_i != $past(status_i)) |=> done_o);   // R8
   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pass_o != fail_o));   // R9
   AST_NO_STRAY_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> !(pass_o || fail_o));   // R9
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> !$rose(start_o));   // R11
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);   // R12
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!tx_valid_o && !busy_o));   // R12
endmodule

// File: tb/sim_rcfg_stream_host.sv
module sim_rcfg_stream_host;
   localparam int DW = 16;
   localparam int IW = 4;
   localparam int TW = 8;
   localparam int SW = 3;
   localparam int SC = 2;
   localparam logic [DW-1:0] FILL = 16'hF11A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          req = 1'b0;
   logic [IW-1:0] last_idx = '0;
   logic [TW-1:0] tmo = 8'd200;
   logic          rdy = 1'b0;
   logic          freeze = 1'b0;
   logic [SW-1:0] status = '0;
   int            pat = 0;

   logic [IW-1:0] sidx0, sidx1;
   logic [DW-1:0] sdat0, sdat1, data0, data1;
   logic start0, vld0, busy0, done0, pass0, fail0;
   logic start1, vld1, busy1, done1, pass1, fail1;

   function automatic logic [DW-1:0] wdat(input int i);
      logic [3:0] k;
      k = 4'(i);
      return {k, ~k, k ^ 4'h9, 4'h3};
   endfunction

   assign sdat0 = wdat(int'(sidx0));
   assign sdat1 = wdat(int'(sidx1));

   rcfg_stream_host #(.DATA_W(DW), .IDX_W(IW), .STAT_W(SW), .TMO_W(TW),
      .START_CYC(SC), .FILL_EN(1), .FILL_VAL(FILL), .OK_CODE(1)) u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .last_idx_i(last_idx),
      .tmo_limit_i(tmo), .src_idx_o(sidx0), .src_data_i(sdat0),
      .start_o(start0), .tx_data_o(data0), .tx_valid_o(vld0),
      .tx_ready_i(rdy), .freeze_i(freeze), .status_i(status),
      .busy_o(busy0), .done_o(done0), .pass_o(pass0), .fail_o(fail0));

   rcfg_stream_host #(.DATA_W(DW), .IDX_W(IW), .STAT_W(SW), .TMO_W(TW),
      .START_CYC(SC), .FILL_EN(0), .FILL_VAL(FILL), .OK_CODE(1)) u1 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .last_idx_i(last_idx),
      .tmo_limit_i(tmo), .src_idx_o(sidx1), .src_data_i(sdat1),
      .start_o(start1), .tx_data_o(data1), .tx_valid_o(vld1),
      .tx_ready_i(rdy), .freeze_i(freeze), .status_i(status),
      .busy_o(busy1), .done_o(done1), .pass_o(pass1), .fail_o(fail1));

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   int cyc = 0, n_acc = 0, n_starts = 0, n_done = 0, done_cyc = 0, hs_cyc = 0, slen = 0;
   int exp_idx = 0, cur_last = 0;
   bit in_post = 0, got_pass = 0, pvld = 0, prdy = 0, pstart = 0, pdone = 0;
   logic [DW-1:0] pdat = '0;

   always @(posedge clk) begin
      #2;
      case (pat)
         0: rdy <= 1'b1;
         1: rdy <= cyc[0];
         2: rdy <= (cyc % 3) != 0;
         default: rdy <= ((cyc * 7) % 5) < 2;
      endcase
   end

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (start0 && !pstart) begin
            n_starts++;
            exp_idx = 0;
            in_post = 0;
            n_acc = 0;
            slen = 0;
         end
         if (start0) slen++;
         if (!start0 && pstart) chk(slen == SC, "R2", slen, SC);
         if (in_post && !done0) chk(!vld1, "R6", vld1, 0);
         if (pvld && !prdy && !done0)
            chk(vld0 && data0 == pdat, "R4", data0, pdat);
         if (vld0 && start0 && !in_post && exp_idx == cur_last)
            chk(1'b0, "R5", start0, 0);
         if (vld0 && rdy) begin
            if (in_post) chk(data0 == FILL, "R6", data0, FILL);
            else begin
               chk(data0 == wdat(exp_idx), "R3", data0, wdat(exp_idx));
               n_acc++;
               if (exp_idx == cur_last) begin
                  chk(!start0, "R5", start0, 0);
                  in_post = 1;
                  hs_cyc = cyc;
               end
               exp_idx++;
            end
         end else if (in_post && !done0) begin
            chk(vld0, "R6", vld0, 1);
         end
         if (done0) begin
            n_done++;
            done_cyc = cyc;
            got_pass = pass0;
            chk(!vld0 && !busy0, "R12", vld0, 0);
            chk(pass0 != fail0, "R9", pass0, !fail0);
            in_post = 0;
         end else begin
            chk(!pass0 && !fail0, "R9", pass0 | fail0, 0);
         end
         if (done0 && pdone) chk(1'b0, "R12", done0, 0);
         pvld = vld0;
         prdy = rdy;
         pdat = data0;
         pstart = start0;
         pdone = done0;
      end
   end

   // mode 0: freeze falls, 1: status OK, 2: status error mid-stream, 3: timeout
   task automatic run(input int last, input int pt, input int mode);
      int s0, d0, ev;
      bit exp_pass;
      pat = pt;
      last_idx = IW'(last);
      cur_last = last;
      tmo = (mode == 3) ? 8'd4 : 8'd200;
      status = '0;
      freeze = 1'b0;
      s0 = n_starts;
      d0 = n_done;
      ev = 0;
      @(posedge clk); #2 req = 1'b1;
      @(posedge clk); #2 req = 1'b0; freeze = 1'b1;
      @(negedge clk);
      chk(busy0 && start0, "R2", {busy0, start0}, 3);
      case (mode)
         0: begin
            if (last >= 3) begin
               wait (n_acc >= 2);
               @(posedge clk); #2 req = 1'b1;
               @(posedge clk); #2 req = 1'b0;
            end
            wait (in_post);
            repeat (3) @(posedge clk);
            #2 freeze = 1'b0;
            ev = cyc;
         end
         1: begin
            wait (in_post);
            repeat (2) @(posedge clk);
            #2 status = 3'd1;
            ev = cyc;
         end
         2: begin
            wait (n_acc >= 1);
            @(posedge clk);
            #2 status = 3'd5;
            ev = cyc;
         end
         default: ;
      endcase
      wait (n_done > d0);
      exp_pass = (mode <= 1);
      if (mode == 0) chk(done_cyc == ev + 2, "R7", done_cyc - ev, 2);
      if (mode == 1 || mode == 2) chk(done_cyc == ev + 2, "R8", done_cyc - ev, 2);
      if (mode == 3) chk(done_cyc == hs_cyc + int'(tmo) + 2, "R10", done_cyc - hs_cyc, int'(tmo) + 2);
      chk(got_pass == exp_pass, "R9", got_pass, exp_pass);
      if (mode != 2) chk(n_acc == last + 1, "R3", n_acc, last + 1);
      chk(n_starts == s0 + 1, "R11", n_starts - s0, 1);
      @(negedge clk);
      chk(!done0 && !busy0, "R12", done0, 0);
      @(posedge clk); #2 freeze = 1'b0; status = '0;
      repeat (2) @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk(!start0 && !vld0 && !busy0, "R1", {start0, vld0, busy0}, 0);
      chk(!done0 && !pass0 && !fail0, "R1", {done0, pass0, fail0}, 0);
      chk(!start1 && !vld1 && !busy1 && !done1, "R1", {start1, vld1, busy1, done1}, 0);
      for (int l = 0; l < 8; l++)
         for (int p = 0; p < 4; p++)
            run(l, p, 0);
      run(5, 1, 1);
      run(0, 2, 1);
      run(4, 2, 2);
      run(6, 0, 2);
      run(3, 1, 3);
      run(0, 0, 3);
      run(7, 3, 3);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule